// File: doc/BRIEF.md
# Stuck-at Fault Test Station

The block wraps a three-input combinational circuit under test, y = x1·x2 + x3, which is built from five numbered wires. Any single wire can be held at a constant 0 or 1 by a fault-select code. Codes 1 to 10 each select one such fault, and every other code leaves the circuit intact.

A start pulse latches the code and begins a run. A sequencer then applies a stored list of four vectors to the circuit, one vector per clock. A comparator checks the circuit output against the stored fault-free response for each vector. The first mismatch sets a sticky detection flag and records the index of the vector that caught it. Both stay visible, together with a done flag, until the next start.

The default vector list is a minimal single-fault test set. Every one of the ten single stuck-at faults fails on at least one of its vectors.

Top module: `fault_test_station`

## Requirements
- R1: With no fault selected, every applied vector produces the fault-free output x1·x2 + x3, so a run ends with `fault_detected` low and `first_fail_index` at 0.
- R2: The fault code picks the wire as (code+1)/2 and the stuck value as 0 for odd codes and 1 for even codes. Wires are numbered 1 = x1, 2 = x2, 3 = x3, 4 = AND output, 5 = circuit output. Codes 0 and 11 to 15 inject nothing.
- R3: Vectors are applied in index order 0 to 3, one per clock starting in the cycle after the start edge. They are 010, 011, 100, 110, written x1 x2 x3 from MSB to LSB, with fault-free responses 0, 1, 0, 1.
- R4: `fault_detected` rises on the first vector whose output differs from its stored response. `first_fail_index` then holds that vector's index, and later mismatches change neither.
- R5: `busy` is high for exactly four cycles after the start edge. `done` rises as `busy` falls, and `done`, `fault_detected` and `first_fail_index` hold until the next accepted start.
- R6: A start pulse while `busy` is high is ignored.
- R7: `fault_sel` is sampled only at an accepted start. Changing it during or after a run does not alter that run's result.
- R8: Each of the ten codes 1 to 10 is detected. The first failing index is 3, 0, 3, 2, 1, 0, 3, 0, 1, 0 for codes 1 to 10.
- R9: After reset, `busy`, `done` and `fault_detected` are low and `first_fail_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begins a run when the block is not busy |
| fault_sel | input | 4 | Fault code, sampled at start |
| busy | output | 1 | Vectors are being applied |
| done | output | 1 | The last vector has been applied |
| fault_detected | output | 1 | A mismatch occurred during the run |
| first_fail_index | output | 2 | Index of the first mismatching vector |

## Verification
On every cycle, the assertions check four things. `busy` and `done` are never high together. The vector index steps by one while a run is in progress. A start during a run cannot extend or restart it. The detection flag and the failing index stay frozen once a mismatch has been seen, and `done` holds until a start.

Only the bench scenarios can show that the stuck-at mapping is correct. They run all ten fault codes and the unused codes, and they confirm that each fault is caught at the predicted vector. They also show that the fault-free run stays clean and that changes to `fault_sel` during a run are ignored.

// File: rtl/stuck_pkg.sv
package stuck_pkg;
  localparam int unsigned FAULT_W   = 4;
  localparam int unsigned NUM_WIRES = 5;
  localparam int unsigned NUM_FAULTS = 2 * NUM_WIRES;
  localparam int unsigned VEC_W     = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} run_state_t;

  // Forces a wire when the code selects it; otherwise the wire passes its value.
  function automatic logic apply_stuck(input logic val,
                                       input int unsigned wire_id,
                                       input logic [FAULT_W-1:0] code);
    int unsigned c;
    c = int'(code);
    if (c >= 1 && c <= NUM_FAULTS && ((c + 1) / 2) == wire_id)
      return ~code[0];
    return val;
  endfunction
endpackage

// File: rtl/stuck_cut.sv
module stuck_cut
  import stuck_pkg::*;
(
  input  logic [VEC_W-1:0]   vec,
  input  logic [FAULT_W-1:0] code,
  output logic               y
);
  logic [NUM_WIRES:1] w;

  always_comb begin
    w[1] = apply_stuck(vec[2], 1, code);
    w[2] = apply_stuck(vec[1], 2, code);
    w[3] = apply_stuck(vec[0], 3, code);
    w[4] = apply_stuck(w[1] & w[2], 4, code);
    w[5] = apply_stuck(w[4] | w[3], 5, code);
  end

  assign y = w[5];
endmodule

// File: rtl/vector_rom.sv
module vector_rom
  import stuck_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned IDX_W   = 2,
  parameter logic [NUM_VEC*VEC_W-1:0] VEC_LIST = {3'b110, 3'b100, 3'b011, 3'b010},
  parameter logic [NUM_VEC-1:0]       EXP_LIST = 4'b1010
)(
  input  logic [IDX_W-1:0] idx,
  output logic [VEC_W-1:0] vec,
  output logic             exp_y
);
  logic [VEC_W-1:0] vec_arr [NUM_VEC];

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_unpack
    assign vec_arr[i] = VEC_LIST[i*VEC_W +: VEC_W];
  end

  assign vec   = vec_arr[idx];
  assign exp_y = EXP_LIST[idx];
endmodule

// File: rtl/run_sequencer.sv
module run_sequencer
  import stuck_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned IDX_W   = 2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FAULT_W-1:0] fault_sel,
  input  logic               mismatch,
  output logic [IDX_W-1:0]   vec_idx,
  output logic [FAULT_W-1:0] code,
  output logic               busy,
  output logic               done,
  output logic               detected,
  output logic [IDX_W-1:0]   fail_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VEC - 1);

  run_state_t         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d, fidx_q, fidx_d;
  logic [FAULT_W-1:0] code_q, code_d;
  logic               det_q, det_d;
  logic               run_en, load_en;

  assign run_en  = (state_q == ST_RUN);
  assign load_en = (state_q != ST_RUN) && start;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    code_d  = code_q;
    det_d   = det_q;
    fidx_d  = fidx_q;
    if (run_en) begin
      if (mismatch && !det_q) begin
        det_d  = 1'b1;
        fidx_d = idx_q;
      end
      if (idx_q == LAST_IDX) state_d = ST_DONE;
      else                   idx_d   = idx_q + 1'b1;
    end else if (load_en) begin
      state_d = ST_RUN;
      idx_d   = '0;
      code_d  = fault_sel;
      det_d   = 1'b0;
      fidx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      code_q  <= '0;
      det_q   <= 1'b0;
      fidx_q  <= '0;
    end else if (run_en || load_en) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      code_q  <= code_d;
      det_q   <= det_d;
      fidx_q  <= fidx_d;
    end
  end

  assign vec_idx  = idx_q;
  assign code     = code_q;
  assign busy     = run_en;
  assign done     = (state_q == ST_DONE);
  assign detected = det_q;
  assign fail_idx = fidx_q;
endmodule

// File: rtl/fault_test_station.sv
module fault_test_station
  import stuck_pkg::*;
#(
  parameter int unsigned NUM_VEC = 4,
  localparam int unsigned IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FAULT_W-1:0] fault_sel,
  output logic               busy,
  output logic               done,
  output logic               fault_detected,
  output logic [IDX_W-1:0]   first_fail_index
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic [IDX_W-1:0]   vec_idx;
  logic [VEC_W-1:0]   cur_vec;
  logic               exp_y, cut_y, mismatch;
  logic [FAULT_W-1:0] act_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  vector_rom #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_rom (
    .idx(vec_idx), .vec(cur_vec), .exp_y(exp_y)
  );

  stuck_cut u_cut (.vec(cur_vec), .code(act_code), .y(cut_y));

  assign mismatch = (cut_y != exp_y);

  run_sequencer #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .fault_sel(fault_sel),
    .mismatch(mismatch), .vec_idx(vec_idx), .code(act_code),
    .busy(busy), .done(done), .detected(fault_detected),
    .fail_idx(first_fail_index)
  );
endmodule

// File: rtl/fault_test_station_chk.sv
module fault_test_station_chk #(
  parameter int unsigned NUM_VEC = 4,
  parameter int unsigned IDX_W   = 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fault_detected,
  input logic [IDX_W-1:0] first_fail_index,
  input logic [IDX_W-1:0] vec_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_VEC - 1);

  // R5
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  detect_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fault_detected) |=> fault_detected);

  // R4
  fail_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fault_detected) |=> $stable(first_fail_index));

  // R3
  vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vec_idx != LAST_IDX) |=> (busy && vec_idx == IDX_W'($past(vec_idx) + 1'b1)));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vec_idx == LAST_IDX) |=> (done && !busy));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fault_detected) && $stable(first_fail_index)));
endmodule

bind fault_test_station fault_test_station_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fault_detected(fault_detected), .first_fail_index(first_fail_index),
  .vec_idx(vec_idx)
);

// File: tb/fault_test_station_test.sv
module fault_test_station_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  typedef struct {
    int       code;
    logic     det;
    int       idx;
  } exp_item_t;

  logic       clk, rst_n, start;
  logic [3:0] fault_sel;
  logic       busy, done, fault_detected;
  logic [1:0] first_fail_index;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;
  exp_item_t sb_q[$];
  logic done_prev = 1'b0;

  fault_test_station uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fault_sel(fault_sel),
    .busy(busy), .done(done), .fault_detected(fault_detected),
    .first_fail_index(first_fail_index)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reduced functions per fault code, written from R1/R2.
  function automatic logic model_y(input logic [2:0] v, input int code);
    logic a, b, c;
    a = v[2]; b = v[1]; c = v[0];
    case (code)
      1, 3, 7: return c;
      2:       return b | c;
      4:       return a | c;
      5:       return a & b;
      6, 8, 10: return 1'b1;
      9:       return 1'b0;
      default: return (a & b) | c;
    endcase
  endfunction

  function automatic logic [2:0] vec_at(input int i);
    case (i)
      0: return 3'b010;
      1: return 3'b011;
      2: return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  // Driver: pushes expected result, starts a run, checks R5 timing.
  task automatic run_case(input int code, input bit disturb);
    exp_item_t it;
    it.code = code; it.det = 1'b0; it.idx = 0;
    for (int i = 0; i < NVEC; i++) begin
      if (!it.det && model_y(vec_at(i), code) != model_y(vec_at(i), 0)) begin
        it.det = 1'b1; it.idx = i;
      end
    end
    sb_q.push_back(it);
    @(negedge clk);
    fault_sel = 4'(code);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5", "busy after start", int'(busy), 1);
    for (int k = 1; k < NVEC; k++) begin
      @(negedge clk);
      if (disturb && k == 1) begin
        // R6 R7: new code and start pulse during the run
        fault_sel = 4'(code ^ 5);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      check("R5", "busy during run", int'(busy), 1);
    end
    start = 1'b0;
    @(negedge clk);
    check("R5", "done after last vector", int'(done), 1);
    check("R6", "busy low at end", int'(busy), 0);
    @(negedge clk);
  endtask

  // Monitor: on each rise of done, pops and compares the scoreboard.
  always @(negedge clk) begin
    if (done && !done_prev) begin
      if (sb_q.size() == 0) begin
        check("R5", "unexpected done", 1, 0);
      end else begin
        exp_item_t e;
        e = sb_q.pop_front();
        if (e.code == 0)
          check("R1", "fault-free detected", int'(fault_detected), 0);
        else if (e.code > 10)
          check("R2", $sformatf("unused code %0d detected", e.code), int'(fault_detected), 0);
        else
          check("R8", $sformatf("code %0d detected", e.code), int'(fault_detected), 1);
        check("R4", $sformatf("code %0d first index", e.code), int'(first_fail_index), e.idx);
      end
    end
    done_prev <= done;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; fault_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9
    check("R9", "busy", int'(busy), 0);
    check("R9", "done", int'(done), 0);
    check("R9", "fault_detected", int'(fault_detected), 0);
    check("R9", "first_fail_index", int'(first_fail_index), 0);

    // R1 R3 fault-free run
    run_case(0, 0);
    // R2 R8 every single fault
    for (int c = 1; c <= 10; c++) run_case(c, 0);
    // R2 unused codes
    run_case(11, 0);
    run_case(15, 0);
    // R6 R7 disturbed runs
    run_case(5, 1);
    run_case(0, 1);

    // R5 R7 results hold while fault_sel moves after the run
    fault_sel = 4'd9;
    repeat (3) @(negedge clk);
    check("R5", "done held", int'(done), 1);
    check("R7", "detected held", int'(fault_detected), 0);
    check("R7", "index held", int'(first_fail_index), 0);

    // R5 a new start clears done
    @(negedge clk);
    start = 1'b1; fault_sel = 4'd9;
    @(negedge clk);
    start = 1'b0;
    check("R5", "done cleared by start", int'(done), 0);
    sb_q.push_back('{code: 9, det: 1'b1, idx: 1});
    repeat (NVEC + 1) @(negedge clk);

    check("R8", "scoreboard drained", sb_q.size(), 0);
    finish_run();
  end
endmodule